// File: doc/BRIEF.md
# Dual-Channel Phase-Shift Dimming Controller

This block converts one digital dimming PWM input into two channel enables for a pair of LED buck channels. A mode input selects between aligned operation, where both enables follow the dimming input together, and spread operation, where channel 2 lags channel 1 by half of the dimming period. Spreading the two conduction windows lowers the peak load on the shared input supply. A sync output carries the shaped dimming waveform so that a downstream controller can lock its own phase offset to it.

The dimming period is measured on chip, in clock cycles, from one rising edge of the input to the next. Channel 2 is made from channel 1 by replaying each edge of channel 1 after half of the most recent measurement. Each high pulse is stretched to a minimum width. When the input stays high for too long, it is treated as a constant-on request: both channels are held on, the period measurement is discarded, and both channels turn off together when the input finally falls. All time limits are set in microseconds or milliseconds and converted to clock cycles using a clock frequency parameter.

Top module: `dual_dim_phase`

## Requirements
- R1: While `align_sel` is 1 (aligned mode), `ch2_en` equals `ch1_en` in every cycle.
- R2: `ch1_en` follows `dim_in` with a latency of SYNC_STAGES+1 clock cycles (3 with defaults), and `sync_out` equals `ch1_en` in every cycle.
- R3: While `align_sel` is 0 (spread mode) and a period is known, `ch2_en` is `ch1_en` delayed by floor(P/2) cycles, where P is the most recently measured rising-to-rising interval of `dim_in` in cycles. A measurement made on a rising edge applies to that pulse and to the ones after it.
- R4: A high pulse of L cycles on `dim_in` gives a `ch1_en` high pulse of max(L, MIN_CYC) cycles, where MIN_CYC is MIN_PULSE_US microseconds of the clock (5 cycles at a 1 MHz clock parameter).
- R5: In spread mode, `ch2_en` equals `ch1_en` with no delay until two rising edges have been seen. This applies after reset and again after a forced-on episode.
- R6: If `dim_in` stays high for STUCK_CYC consecutive cycles (STUCK_MS milliseconds of the clock), both enables are held high until the input falls. They then fall in the same cycle, and the period measurement is discarded. A shorter high pulse does not force anything: in spread mode, `ch2_en` still falls half a period after `ch1_en`.
- R7: During and right after reset, `ch1_en`, `ch2_en` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dim_in | input | 1 | Digital dimming PWM input, asynchronous |
| align_sel | input | 1 | 1: channels in phase; 0: channel 2 shifted by half a period |
| ch1_en | output | 1 | Channel 1 enable |
| ch2_en | output | 1 | Channel 2 enable |
| sync_out | output | 1 | Shaped dimming waveform for a downstream controller |

## Verification
In spread mode, a falling edge of channel 1 can enter the edge queue in the same cycle that an earlier rising edge leaves it for channel 2. This happens when the input's high time is exactly half its period. The bench drives a 200-of-400-cycle pattern. It checks that channel 2 rises in the same cycle that channel 1 falls and that channel 2 keeps the full 200-cycle width, so a lost push or pop would show up. A second overlap occurs when a forced-on release meets a fall that is still pending in the queue. It is judged by requiring that both channels fall in the same cycle after a hold longer than the timeout. A hold just under the timeout must give a 200-cycle gap between the two falls.

// File: rtl/dim_pkg.sv
`timescale 1ns/1ps
package dim_pkg;

   typedef enum logic {
      MODE_SPREAD = 1'b0,
      MODE_ALIGN  = 1'b1
   } dim_mode_e;

   // microseconds -> clock cycles
   function automatic int unsigned us_to_cyc(input int unsigned clk_hz, input int unsigned us);
      return (clk_hz / 1000) * us / 1000;
   endfunction

   // milliseconds -> clock cycles
   function automatic int unsigned ms_to_cyc(input int unsigned clk_hz, input int unsigned ms);
      return (clk_hz / 1000) * ms;
   endfunction

   // counter width able to hold the slowest dimming period, plus one bit of margin
   function automatic int unsigned period_bits(input int unsigned clk_hz, input int unsigned min_hz);
      return $clog2(clk_hz / min_hz) + 1;
   endfunction

endpackage

// File: rtl/dim_sync.sv
`timescale 1ns/1ps
module dim_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dim_shaper.sv
`timescale 1ns/1ps
module dim_shaper #(
   parameter int MIN_CYC   = 5,
   parameter int STUCK_CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_s,
   output logic rise_o,
   output logic en_o,
   output logic forced_o
);
   localparam int HW = $clog2(MIN_CYC + 1);
   localparam int SW = $clog2(STUCK_CYC + 1);
   localparam logic [HW-1:0] HOLD_INIT = HW'(MIN_CYC - 1);
   localparam logic [HW-1:0] HOLD_MAX  = HW'(MIN_CYC);
   localparam logic [SW-1:0] STUCK_MAX = SW'(STUCK_CYC);
   localparam logic [SW-1:0] STUCK_LIM = SW'(STUCK_CYC - 1);

   logic          din_d;
   logic [HW-1:0] hold_q;
   logic [SW-1:0] high_q;
   logic          en_q;
   logic          forced_q;

   assign rise_o   = din_s & ~din_d;
   assign en_o     = en_q;
   assign forced_o = forced_q;

   // stretch counter: remaining cycles the enable must stay high past the first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         din_d  <= 1'b0;
         hold_q <= '0;
         en_q   <= 1'b0;
      end else begin
         din_d <= din_s;
         if (rise_o)              hold_q <= HOLD_INIT;
         else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
         en_q <= din_s | (hold_q != '0);
      end
   end

   // stuck-high detector
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_q   <= '0;
         forced_q <= 1'b0;
      end else begin
         if (!din_s)                  high_q <= '0;
         else if (high_q != STUCK_MAX) high_q <= high_q + 1'b1;
         forced_q <= din_s & (high_q >= STUCK_LIM);
      end
   end

   // run length of the enable, kept only for the width check
   logic [HW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (!en_q)             run_q <= '0;
      else if (run_q != HOLD_MAX) run_q <= run_q + 1'b1;
   end

   assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q) |-> ($past(run_q) >= HOLD_INIT));

   assert_forced_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      forced_q |-> en_q);
endmodule

// File: rtl/dim_period_meter.sv
`timescale 1ns/1ps
module dim_period_meter #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             clear,
   output logic [PER_W-1:0] half_o,
   output logic             valid_o
);
   localparam logic [PER_W-1:0] CNT_MAX = '1;
   localparam logic [PER_W-1:0] MIN_PER = PER_W'(4);

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] half_q;
   logic             seen_q;
   logic             valid_q;

   assign half_o  = half_q;
   assign valid_o = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         half_q  <= '0;
         seen_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (clear) begin
         cnt_q   <= '0;
         seen_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (rise) begin
         if (seen_q) begin
            half_q  <= {1'b0, cnt_q[PER_W-1:1]};
            valid_q <= (cnt_q >= MIN_PER);
         end
         seen_q <= 1'b1;
         cnt_q  <= PER_W'(1);
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_valid_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(rise));
endmodule

// File: rtl/dim_phase_delay.sv
`timescale 1ns/1ps
module dim_phase_delay #(
   parameter int PER_W = 16,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ch1,
   input  logic [PER_W-1:0] half,
   output logic             lvl_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

   logic [PER_W-1:0] due_q [DEPTH];
   logic             val_q [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [AW:0]      cnt_q;
   logic [PER_W-1:0] now_q;
   logic             prev_q;
   logic             lvl_q;
   logic             push, pop;

   assign push  = active & (ch1 != prev_q) & (cnt_q != FULL);
   assign pop   = active & (cnt_q != '0) & (due_q[rd_q] == now_q);
   assign lvl_o = lvl_q;

   always_ff @(posedge clk) begin
      if (push) begin
         due_q[wr_q] <= now_q + half - PER_W'(1);
         val_q[wr_q] <= ch1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q  <= '0;
         prev_q <= 1'b0;
         lvl_q  <= 1'b0;
         wr_q   <= '0;
         rd_q   <= '0;
         cnt_q  <= '0;
      end else begin
         now_q  <= now_q + 1'b1;
         prev_q <= ch1;
         if (!active) begin
            lvl_q <= ch1;
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop) begin
               lvl_q <= val_q[rd_q];
               rd_q  <= rd_q + 1'b1;
            end
            unique case ({push, pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   assert_queue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   assert_idle_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0));
endmodule

// File: rtl/dual_dim_phase.sv
`timescale 1ns/1ps
module dual_dim_phase
   import dim_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 50_000_000,
   parameter int unsigned MIN_PULSE_US = 5,
   parameter int unsigned STUCK_MS     = 25,
   parameter int unsigned MIN_DIM_HZ   = 100,
   parameter int          SYNC_STAGES  = 2,
   parameter int          EDGE_DEPTH   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dim_in,
   input  logic align_sel,
   output logic ch1_en,
   output logic ch2_en,
   output logic sync_out
);
   localparam int MIN_CYC   = int'(us_to_cyc(CLK_HZ, MIN_PULSE_US));
   localparam int STUCK_CYC = int'(ms_to_cyc(CLK_HZ, STUCK_MS));
   localparam int PER_W     = int'(period_bits(CLK_HZ, MIN_DIM_HZ));

   if (MIN_CYC < 1) begin : g_bad_min
      $error("minimum pulse rounds to zero cycles");
   end
   if (STUCK_CYC <= MIN_CYC) begin : g_bad_stuck
      $error("stuck-high limit must exceed the minimum pulse");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchronizer stages are needed");
   end
   if (EDGE_DEPTH < 2 || (EDGE_DEPTH & (EDGE_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("edge queue depth must be a power of two, at least 2");
   end

   logic            din_s, sel_s;
   logic            rise, en1, forced;
   logic [PER_W-1:0] half;
   logic            valid, lvl, active;
   dim_mode_e       mode;

   dim_sync #(.STAGES(SYNC_STAGES)) u_sync_dim (
      .clk(clk), .rst_n(rst_n), .d(dim_in), .q(din_s));

   dim_sync #(.STAGES(SYNC_STAGES)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(align_sel), .q(sel_s));

   dim_shaper #(.MIN_CYC(MIN_CYC), .STUCK_CYC(STUCK_CYC)) u_shape (
      .clk(clk), .rst_n(rst_n), .din_s(din_s),
      .rise_o(rise), .en_o(en1), .forced_o(forced));

   dim_period_meter #(.PER_W(PER_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .rise(rise), .clear(forced),
      .half_o(half), .valid_o(valid));

   assign mode   = dim_mode_e'(sel_s);
   assign active = (mode == MODE_SPREAD) & valid & ~forced;

   dim_phase_delay #(.PER_W(PER_W), .DEPTH(EDGE_DEPTH)) u_delay (
      .clk(clk), .rst_n(rst_n), .active(active), .ch1(en1),
      .half(half), .lvl_o(lvl));

   assign ch1_en   = en1;
   assign sync_out = en1;
   assign ch2_en   = forced | (active ? lvl : en1);

   assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ALIGN) |-> (ch2_en == ch1_en));

   assert_forced_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      forced |-> (ch1_en && ch2_en));
endmodule

// File: tb/sim_dual_dim_phase.sv
`timescale 1ns/1ps
module sim_dual_dim_phase;
   // nominal 1 MHz parameter -> MIN_CYC = 5, STUCK_CYC = 25000
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dim_in = 1'b0;
   logic align_sel = 1'b1;
   logic ch1_en, ch2_en, sync_out;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   dual_dim_phase #(.CLK_HZ(1_000_000)) u0 (
      .clk(clk), .rst_n(rst_n), .dim_in(dim_in), .align_sel(align_sel),
      .ch1_en(ch1_en), .ch2_en(ch2_en), .sync_out(sync_out));

   // output monitor, sampled on the falling edge
   int cyc = 0, r1_at = 0, r2_at = 0, f1_at = 0, f2_at = 0;
   int w1 = 0, w2 = 0, h1 = 0, h2 = 0, neq = 0, nsync = 0;
   logic p1 = 1'b0, p2 = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (ch1_en && !p1) r1_at = cyc;
      if (ch2_en && !p2) r2_at = cyc;
      if (!ch1_en && p1) begin f1_at = cyc; w1 = h1; h1 = 0; end
      if (!ch2_en && p2) begin f2_at = cyc; w2 = h2; h2 = 0; end
      if (ch1_en) h1 = h1 + 1;
      if (ch2_en) h2 = h2 + 1;
      if (ch1_en != ch2_en) neq = neq + 1;
      if (sync_out != ch1_en) nsync = nsync + 1;
      p1 = ch1_en;
      p2 = ch2_en;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      @(posedge clk);
      neq = 0;
      nsync = 0;
   endtask

   task automatic train(input int period, input int high, input int n);
      for (int c = 0; c < n * period; c++) begin
         @(negedge clk);
         dim_in = ((c % period) < high);
      end
      @(posedge clk);
   endtask

   task automatic hold(input int len);
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         dim_in = 1'b1;
      end
      @(negedge clk);
      dim_in = 1'b0;
      repeat (600) @(negedge clk);
      @(posedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      dim_in = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(ch1_en == 1'b0, "R7 ch1 in reset", ch1_en, 0);
      chk(ch2_en == 1'b0, "R7 ch2 in reset", ch2_en, 0);
      chk(sync_out == 1'b0, "R7 sync in reset", sync_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ch1_en == 1'b0 && ch2_en == 1'b0, "R7 after reset", ch1_en + ch2_en, 0);
   endtask

   task automatic t_latency();
      int k;
      align_sel = 1'b1;
      repeat (6) @(negedge clk);
      clr();
      @(negedge clk);
      dim_in = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!ch1_en && k < 10);
      chk(k == 3, "R2 rise latency", k, 3);
      repeat (40) @(negedge clk);
      dim_in = 1'b0;
      repeat (20) @(negedge clk);
      @(posedge clk);
      chk(w1 == 43, "R2 width follows input", w1, 43);
      chk(nsync == 0, "R2 sync equals ch1", nsync, 0);
   endtask

   task automatic t_aligned();
      clr();
      train(400, 120, 5);
      chk(neq == 0, "R1 aligned mismatch cycles", neq, 0);
      chk(w1 == 120, "R1 aligned width", w1, 120);
   endtask

   task automatic t_first_period();
      align_sel = 1'b0;
      do_reset();
      clr();
      train(400, 120, 1);
      chk(neq == 0, "R5 no delay before period known", neq, 0);
      train(400, 120, 4);
      chk(r2_at - r1_at == 200, "R3 half-period shift", r2_at - r1_at, 200);
      chk(w2 == 120, "R3 ch2 width", w2, 120);
      chk(nsync == 0, "R2 sync equals ch1 spread", nsync, 0);
   endtask

   task automatic t_period_change();
      train(600, 120, 3);
      chk(r2_at - r1_at == 300, "R3 new period adopted", r2_at - r1_at, 300);
      chk(w2 == 120, "R3 ch2 width at 600", w2, 120);
   endtask

   task automatic t_overlap();
      train(400, 200, 4);
      chk(r2_at - r1_at == 200, "R3 shift with push and pop together", r2_at - r1_at, 200);
      chk(r2_at == f1_at, "R3 ch2 rises as ch1 falls", r2_at, f1_at);
      chk(w2 == 200, "R3 ch2 width kept", w2, 200);
   endtask

   task automatic t_min_pulse();
      train(400, 2, 4);
      chk(w1 == 5, "R4 two-cycle pulse stretched", w1, 5);
      chk(w2 == 5, "R4 stretched pulse on ch2", w2, 5);
      chk(r2_at - r1_at == 200, "R3 shift with short pulse", r2_at - r1_at, 200);
      train(400, 1, 3);
      chk(w1 == 5, "R4 one-cycle pulse stretched", w1, 5);
   endtask

   task automatic t_stuck();
      hold(24000);
      chk(w1 == 24000, "R6 short hold width", w1, 24000);
      chk(f2_at - f1_at == 200, "R6 no force below limit", f2_at - f1_at, 200);
      hold(25100);
      chk(w1 == 25100, "R6 forced until input falls", w1, 25100);
      chk(f2_at == f1_at, "R6 both fall together", f2_at, f1_at);
      clr();
      train(400, 120, 1);
      chk(neq == 0, "R5 no delay after forced release", neq, 0);
      train(400, 120, 3);
      chk(r2_at - r1_at == 200, "R3 shift resumes", r2_at - r1_at, 200);
   endtask

   task automatic t_mode_switch();
      align_sel = 1'b1;
      repeat (5) @(negedge clk);
      clr();
      train(400, 120, 3);
      chk(neq == 0, "R1 aligned after spread", neq, 0);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_aligned();
      t_first_period();
      t_period_change();
      t_overlap();
      t_min_pulse();
      t_stuck();
      t_mode_switch();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(150_000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule